// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Peripheral Pad Multiplexing

This block is the pad-side front end of a small general-purpose I/O port. It holds two registers on a simple register bus: a data latch that supplies output values, and a direction register whose bits enable each pin's output buffer. Two on-chip peripherals can take pins away from the port. A serial peripheral interface (SPI) can claim four pins: select, data in, data out and clock. A two-channel timer can claim one capture/compare pin per channel. For every pin the block decides who drives the pad value and who drives the pad output enable. The SPI and timer engines are outside this block. It sees only their enable and mode bits, their per-pin output values and their per-pin output enables.

Pad inputs pass through a two-flop synchronizer. The synchronized levels feed both the peripherals and the port read path. A read of the data register follows the direction bits even on pins that a peripheral currently owns. Because the data latch can be written while a pin is still an input, software can preload the output level before it turns the buffer on, which avoids a glitch.

Top module: `gpio_pinmux_port`

## Requirements
- R1: After reset the direction register and the data latch are all zero, every pad output enable is 0, and the direction register reads back as 0x00.
- R2: Bit 7 of both the data register read and the direction register read is always 0. Writing 1 to bit 7 has no effect.
- R3: A pin that no peripheral owns has its pad output enable equal to its direction bit and its pad value equal to its latch bit.
- R4: A read of the data register (address 0) returns the latch bit for each pin whose direction bit is 1, and the synchronized pad level for each pin whose direction bit is 0. This holds whether or not a peripheral owns the pin.
- R5: The data latch accepts writes whatever the direction bits are. While a pin is an unowned input, its pad value already shows the new latch value, and the buffer stays disabled.
- R6: While the SPI enable input is 1, pins 3, 2 and 1 (clock, data out, data in) take their pad value and output enable from bits 3, 2 and 1 of the SPI output and SPI output-enable inputs. The direction register has no effect on these pins.
- R7: Pin 0 (select) belongs to the SPI only when the SPI is enabled and the master input is 0. In that case it takes bit 0 of the SPI output and output-enable inputs. Otherwise it is a plain port pin.
- R8: Timer channel c owns pin 4+c when its two select bits, `tmr_mode[2c+1:2c]`, are not both zero. It then takes its pad value and output enable from `tmr_out[c]` and `tmr_oe[c]`. When both bits are zero, the pin is a plain port pin.
- R9: A register write takes effect on the clock edge that samples `bus_wr` high with address 0 (data) or 1 (direction). Writes to addresses 2 and 3 change nothing, and those addresses read as 0.
- R10: `spi_in` (pins 3..0) and `tmr_in` (pins 5..4) present each pad level two clock edges after it is sampled, and not one edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode |
| spi_out | input | 4 | SPI pad values for pins 3..0 |
| spi_oe | input | 4 | SPI output enables for pins 3..0 |
| spi_in | output | 4 | Synchronized pad levels of pins 3..0 |
| tmr_mode | input | 4 | Edge/level select pairs, two bits per channel |
| tmr_out | input | 2 | Timer pad values for pins 5..4 |
| tmr_oe | input | 2 | Timer output enables for pins 5..4 |
| tmr_in | output | 2 | Synchronized pad levels of pins 5..4 |
| pad_in | input | 7 | Pad input levels |
| pad_out | output | 7 | Pad output values |
| pad_oe | output | 7 | Pad output-buffer enables |

## Verification
The bench steps through mixed ownership patterns: SPI as slave, SPI as master, a single timer channel, and every peripheral at once. These patterns catch a design that hands the select pin to the SPI in master mode, or one that mixes up which select pair belongs to which timer channel. On peripheral-owned pins, the read-back is checked with direction bits that disagree with the peripheral's enables. A design that routes reads through the owner instead of the direction bit would return the wrong bits there. The bench also preloads the latch on input pins, writes to unmapped addresses and to bit 7, and counts synchronizer edges. These tests would expose a latch gated by direction, a stray decode, or a one-flop input path.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    // Pin positions that the ownership decode depends on.
    localparam int PIN_SEL   = 0;
    localparam int PIN_SDI   = 1;
    localparam int PIN_SDO   = 2;
    localparam int PIN_SCLK  = 3;
    localparam int PIN_CAP0  = 4;
    localparam int SPI_PINS  = 4;

    // Register addresses.
    localparam int REG_DATA  = 0;
    localparam int REG_DIR   = 1;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = din;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.stage2;

    // Edges seen since reset, saturating; lets the delay check start cleanly.
    logic [1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    // R10: the output lags the input by exactly two edges.
    a_r10_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 7,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] latch_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [DATA_W-1:0]   bus_rdata
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(REG_DIR);

    typedef struct packed {
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] dir;
    } regs_t;

    regs_t regs_d, regs_q;

    logic wr_data, wr_dir;
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_dir  = bus_wr && (bus_addr == A_DIR);

    always_comb begin
        regs_d = regs_q;
        if (wr_data) begin
            regs_d.latch = bus_wdata[NUM_PINS-1:0];
        end
        if (wr_dir) begin
            regs_d.dir = bus_wdata[NUM_PINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign latch_q = regs_q.latch;
    assign dir_q   = regs_q.dir;

    // Read view: driven pins echo the latch, input pins echo the pad.
    logic [NUM_PINS-1:0] port_view;
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            port_view[i] = regs_q.dir[i] ? regs_q.latch[i] : pin_sync[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_DATA) begin
            bus_rdata = DATA_W'(port_view);
        end else if (bus_addr == A_DIR) begin
            bus_rdata = DATA_W'(regs_q.dir);
        end
    end

    // R9: registers move only on a matching write.
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(latch_q));
    a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));
    // R5: a data write lands whatever the direction bits are.
    a_r5_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (latch_q == $past(bus_wdata[NUM_PINS-1:0])));

    // R2: unimplemented upper read bits stay zero.
    generate
        if (DATA_W > NUM_PINS) begin : g_upper
            always_comb begin
                a_r2_upper_zero: assert (bus_rdata[DATA_W-1:NUM_PINS] == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_pin_owner.sv
module gpio_pin_owner
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 7,
    parameter int TMR_CH   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_en,
    input  logic                spi_master,
    input  logic [2*TMR_CH-1:0] tmr_mode,
    output logic [NUM_PINS-1:0] periph_own
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            if (gi == PIN_SEL) begin : g_sel
                assign periph_own[gi] = spi_en && !spi_master;
            end else if (gi < SPI_PINS) begin : g_spi
                assign periph_own[gi] = spi_en;
            end else if (gi < PIN_CAP0 + TMR_CH) begin : g_tmr
                assign periph_own[gi] = |tmr_mode[2*(gi-PIN_CAP0) +: 2];
            end else begin : g_gpio
                assign periph_own[gi] = 1'b0;
            end
        end
    endgenerate

    // R7: master mode always returns the select pin to the port.
    a_r7_master_frees_sel: assert property (@(posedge clk) disable iff (!rst_n)
        spi_master |-> !periph_own[PIN_SEL]);
    // R6: with the SPI disabled no SPI pin is claimed.
    a_r6_spi_off_frees: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> (periph_own[SPI_PINS-1:0] == '0));

endmodule

// File: rtl/gpio_pinmux_port.sv
module gpio_pinmux_port
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 7,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter int TMR_CH   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                spi_en,
    input  logic                spi_master,
    input  logic [SPI_PINS-1:0] spi_out,
    input  logic [SPI_PINS-1:0] spi_oe,
    output logic [SPI_PINS-1:0] spi_in,
    input  logic [2*TMR_CH-1:0] tmr_mode,
    input  logic [TMR_CH-1:0]   tmr_out,
    input  logic [TMR_CH-1:0]   tmr_oe,
    output logic [TMR_CH-1:0]   tmr_in,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    localparam int PERIPH_PINS = PIN_CAP0 + TMR_CH;
    localparam int SPARE_PINS  = NUM_PINS - PERIPH_PINS;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] latch_q, dir_q;
    logic [NUM_PINS-1:0] periph_own;
    logic [NUM_PINS-1:0] periph_out, periph_oe;

    gpio_in_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_sync)
    );

    gpio_port_regs #(
        .NUM_PINS(NUM_PINS),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pin_sync (pin_sync),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .bus_rdata(bus_rdata)
    );

    gpio_pin_owner #(
        .NUM_PINS(NUM_PINS),
        .TMR_CH  (TMR_CH)
    ) i_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_en    (spi_en),
        .spi_master(spi_master),
        .tmr_mode  (tmr_mode),
        .periph_own(periph_own)
    );

    // Peripheral drive gathered onto pin positions.
    generate
        if (SPARE_PINS > 0) begin : g_spare
            assign periph_out = {{SPARE_PINS{1'b0}}, tmr_out, spi_out};
            assign periph_oe  = {{SPARE_PINS{1'b0}}, tmr_oe,  spi_oe};
        end else begin : g_full
            assign periph_out = {tmr_out, spi_out};
            assign periph_oe  = {tmr_oe,  spi_oe};
        end
    endgenerate

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_mux
            always_comb begin
                if (periph_own[gi]) begin
                    pad_out[gi] = periph_out[gi];
                    pad_oe[gi]  = periph_oe[gi];
                end else begin
                    pad_out[gi] = latch_q[gi];
                    pad_oe[gi]  = dir_q[gi];
                end
            end
        end
    endgenerate

    assign spi_in = pin_sync[SPI_PINS-1:0];
    assign tmr_in = pin_sync[PERIPH_PINS-1:PIN_CAP0];

    // R6: an enabled SPI drives its three fixed pins.
    a_r6_spi_drives: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (pad_oe[PIN_SCLK:PIN_SDI] == spi_oe[PIN_SCLK:PIN_SDI]
                    && pad_out[PIN_SCLK:PIN_SDI] == spi_out[PIN_SCLK:PIN_SDI]));
    // R7: in master mode the select pin follows the registers.
    a_r7_sel_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        spi_master |-> (pad_oe[PIN_SEL] == dir_q[PIN_SEL]
                        && pad_out[PIN_SEL] == latch_q[PIN_SEL]));
    // R8: an idle timer channel leaves its pin to the port.
    a_r8_tmr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_mode[1:0] == 2'b00) |-> (pad_oe[PIN_CAP0] == dir_q[PIN_CAP0]));
    // R3: the spare top pin is always a port pin.
    a_r3_spare_pin: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[NUM_PINS-1] == dir_q[NUM_PINS-1]);

endmodule

// File: tb/test_gpio_pinmux_port.sv
module test_gpio_pinmux_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_en = 1'b0, spi_master = 1'b0;
    logic [3:0] spi_out = '0, spi_oe = '0, spi_in;
    logic [3:0] tmr_mode = '0;
    logic [1:0] tmr_out = '0, tmr_oe = '0, tmr_in;
    logic [6:0] pad_in = '0, pad_out, pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_pinmux_port i_gpio_pinmux_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_en(spi_en), .spi_master(spi_master), .spi_out(spi_out),
        .spi_oe(spi_oe), .spi_in(spi_in), .tmr_mode(tmr_mode),
        .tmr_out(tmr_out), .tmr_oe(tmr_oe), .tmr_in(tmr_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic       en;
        logic       mst;
        logic [3:0] mode;
        logic [6:0] dir;
        logic [6:0] latch;
        logic [3:0] s_out;
        logic [3:0] s_oe;
        logic [1:0] t_out;
        logic [1:0] t_oe;
        logic [6:0] pin;
        logic [6:0] exp_out;
        logic [6:0] exp_oe;
    } vec_t;

    // R3 R6 R7 R8 ownership patterns with hand-derived pad results.
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 4'b0000, 7'h55, 7'h33, 4'hF, 4'hF, 2'b11, 2'b11, 7'h7F, 7'h33, 7'h55},
        '{1'b1, 1'b0, 4'b0000, 7'h7F, 7'h00, 4'hA, 4'h5, 2'b11, 2'b11, 7'h2A, 7'h0A, 7'h75},
        '{1'b1, 1'b1, 4'b0000, 7'h00, 7'h7F, 4'h0, 4'hF, 2'b00, 2'b00, 7'h15, 7'h71, 7'h0E},
        '{1'b0, 1'b0, 4'b0100, 7'h0F, 7'h50, 4'hF, 4'hF, 2'b01, 2'b10, 7'h66, 7'h50, 7'h2F},
        '{1'b0, 1'b0, 4'b0010, 7'h30, 7'h2A, 4'h0, 4'h0, 2'b11, 2'b01, 7'h4C, 7'h3A, 7'h30},
        '{1'b1, 1'b0, 4'b1001, 7'h40, 7'h40, 4'h6, 4'h3, 2'b10, 2'b11, 7'h3B, 7'h66, 7'h73}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        #1 check("R1 pad_oe at reset", {1'b0, pad_oe}, 8'h00);
        check("R1 pad_out at reset", {1'b0, pad_out}, 8'h00);
        rst_n = 1'b1;
        reg_read(2'd1, rd);
        check("R1 dir reads zero", rd, 8'h00);

        // Vector table
        for (int k = 0; k < 6; k++) begin
            reg_write(2'd0, {1'b0, VECS[k].latch});
            reg_write(2'd1, {1'b0, VECS[k].dir});
            @(negedge clk);
            spi_en = VECS[k].en; spi_master = VECS[k].mst; tmr_mode = VECS[k].mode;
            spi_out = VECS[k].s_out; spi_oe = VECS[k].s_oe;
            tmr_out = VECS[k].t_out; tmr_oe = VECS[k].t_oe;
            pad_in = VECS[k].pin;
            repeat (3) @(negedge clk);
            #1;
            check($sformatf("R3/R6/R7/R8 pad_out vec %0d", k), {1'b0, pad_out}, {1'b0, VECS[k].exp_out});
            check($sformatf("R3/R6/R7/R8 pad_oe vec %0d", k), {1'b0, pad_oe}, {1'b0, VECS[k].exp_oe});
            reg_read(2'd0, rd);
            check($sformatf("R4 data read vec %0d", k), rd,
                  {1'b0, (VECS[k].dir & VECS[k].latch) | (~VECS[k].dir & VECS[k].pin)});
        end

        // Back to plain port for directed tests.
        @(negedge clk);
        spi_en = 0; spi_master = 0; tmr_mode = '0; spi_out = '0; spi_oe = '0;
        tmr_out = '0; tmr_oe = '0; pad_in = 7'h00;

        // R2: bit 7 ignored
        reg_write(2'd1, 8'hFF);
        reg_read(2'd1, rd);
        check("R2 dir bit7 reads zero", rd, 8'h7F);
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, rd);
        check("R2 data bit7 reads zero", rd, 8'h7F);

        // R5: preload latch while pins are inputs
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h55);
        #1 check("R5 preload visible on pad_out", {1'b0, pad_out}, 8'h55);
        check("R5 buffers stay off", {1'b0, pad_oe}, 8'h00);
        reg_write(2'd1, 8'h7F);
        reg_read(2'd0, rd);
        check("R5 latch read after enable", rd, 8'h55);

        // R9: unmapped addresses and write timing
        reg_write(2'd2, 8'h00);
        reg_write(2'd3, 8'h00);
        reg_read(2'd1, rd);
        check("R9 dir unchanged by unmapped write", rd, 8'h7F);
        #1 check("R9 latch unchanged by unmapped write", {1'b0, pad_out}, 8'h55);
        reg_read(2'd2, rd);
        check("R9 unmapped reads zero", rd, 8'h00);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h2A;
        #1 check("R9 no change before edge", {1'b0, pad_out}, 8'h55);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R9 change after edge", {1'b0, pad_out}, 8'h2A);

        // R4: read follows direction while SPI owns pins
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h0F);
        @(negedge clk);
        spi_en = 1'b1; spi_oe = 4'h0; pad_in = 7'h7F;
        repeat (3) @(negedge clk);
        reg_read(2'd0, rd);
        check("R4 read on SPI-owned pins", rd, 8'h70);
        @(negedge clk);
        spi_en = 1'b0; pad_in = 7'h00;
        repeat (3) @(negedge clk);

        // R10: two-edge synchronizer
        @(negedge clk);
        pad_in = 7'h3F;
        @(negedge clk);
        #1 check("R10 spi_in after one edge", {4'h0, spi_in}, 8'h00);
        check("R10 tmr_in after one edge", {6'h0, tmr_in}, 8'h00);
        @(negedge clk);
        #1 check("R10 spi_in after two edges", {4'h0, spi_in}, 8'h0F);
        check("R10 tmr_in after two edges", {6'h0, tmr_in}, 8'h03);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule